// File: doc/BRIEF.md
# Aligned 16-Byte Line Move Unit

This execution unit copies one 16-byte memory line from a source address to a destination address for a 32-bit processor. Both addresses are rounded down to a 16-byte boundary, so each move covers exactly one aligned line. The unit accepts one command, made of a 16-bit opcode and its extension data, through a valid/ready handshake. The extension data is either a register-select word in bits 15:0 or a full 32-bit absolute address. The unit reads a bank of eight 32-bit address registers, which are presented flattened on one input, and returns post-incremented values through per-register write strobes.

A move is two 64-bit reads from the source line, low half first. Two 64-bit writes of the same data to the destination line follow, in the same order. Every beat is a request that the memory side accepts with an acknowledge (`mem_ack`). Until that acknowledge arrives, the unit holds the address, the direction, the write data and the privilege tag stable. It issues the next beat only after the current one is acknowledged, so the memory side controls the pace.

While a move is running, `cmd_ready` stays low, so a command offered on `cmd_valid` waits. Register write-back happens only in the single `done` cycle. A stalled move therefore leaves the register bank untouched. Malformed commands produce a one-cycle `illegal` pulse and nothing else.

Top module: `line_mover`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. The absolute forms are recognised when (opcode & 16'hFFE0) == 16'hF600. The register-pair form is recognised when (opcode & 16'hFFF8) == 16'hF620. Any other opcode is illegal.
- R2: Every memory beat address has its low four bits equal to the beat offset (0 or 8) on top of the source or destination address with bits 3:0 cleared.
- R3: The beats of a move come in this fixed order: read at source, read at source+8, write at destination, write at destination+8. The first write carries the first read's data, and the second write carries the second read's data.
- R4: In the register-pair form, the source register is opcode[2:0] and the destination register is cmd_ext[14:12].
- R5: In the register-pair form, cmd_ext[15] = 0 is illegal. An illegal command (R5 or R1) raises `illegal` for exactly the one cycle after acceptance. It issues no memory beat, writes no register and leaves `cmd_ready` high.
- R6: In the register-pair form, both registers are written with their value at acceptance plus 16. When both fields name the same register, that register ends at its original value plus 16.
- R7: In the absolute forms, the address register is opcode[2:0]. With opcode[3] = 1 the line moves from the absolute address cmd_ext to the register's address. With opcode[3] = 0 it moves from the register's address to cmd_ext.
- R8: In the absolute forms, opcode[4] = 0 writes the address register with its value plus 16. With opcode[4] = 1, no register is written.
- R9: While `mem_valid` is high and `mem_ack` is low, `mem_addr`, `mem_we`, `mem_wdata` and `mem_user` hold their values in the next cycle. Each beat's `mem_user` equals `user_mode` as sampled at acceptance.
- R10: `done` is high for exactly one cycle, the cycle after the final write is acknowledged. `areg_wr_en` is nonzero only in that cycle.
- R11: `busy` is high and `cmd_ready` is low from the cycle after a legal command is accepted through its `done` cycle. A `cmd_valid` offered during that time starts no beat.
- R12: During and after reset, `mem_valid`, `busy`, `done`, `illegal` and `areg_wr_en` are low, and `cmd_ready` is high. A reset in the middle of a move abandons it without writing any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_opcode | input | 16 | Operation word |
| cmd_ext | input | AW (32) | Extension data: select word in [15:0] or absolute address |
| user_mode | input | 1 | Privilege of the command, 1 = user |
| areg_q | input | NREG*AW (256) | Current address registers, register i at [i*AW +: AW] |
| areg_wr_en | output | NREG (8) | Per-register write strobe |
| areg_wr_data | output | NREG*AW (256) | Write-back values, same packing as areg_q |
| mem_valid | output | 1 | Memory beat request |
| mem_ack | input | 1 | Memory accepts the current beat (read data valid with it) |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW (32) | Beat byte address |
| mem_wdata | output | DW (64) | Write beat data |
| mem_rdata | input | DW (64) | Read beat data, taken when mem_ack is high |
| mem_user | output | 1 | Privilege tag of the beat |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-command pulse |

## Verification
A wrong beat counter or state shows at the ports within one acknowledge. The next beat's address, its direction or the data it carries differs from the fixed read-read-write-write order. Alternatively, the move never reaches `done`. A wrong captured select or increment shows only in the `done` cycle, as a wrong strobe or value on `areg_wr_en`/`areg_wr_data`. For that reason the bench compares the whole register bank after each move. The bench also watches every cycle for strobes outside `done`. A decode fault shows one cycle after acceptance, either as a missing or spurious `illegal` pulse or as a first read at the wrong line.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int LM_SEL_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } lm_state_t;

  typedef struct packed {
    logic                legal;
    logic                src_abs;
    logic                dst_abs;
    logic [LM_SEL_W-1:0] src_sel;
    logic [LM_SEL_W-1:0] dst_sel;
    logic                inc_src;
    logic                inc_dst;
  } lm_dec_t;
endpackage

// File: rtl/lm_decode.sv
module lm_decode
  import lm_pkg::*;
(
  input  logic [15:0] opcode,
  input  logic [3:0]  ext_hi,
  output lm_dec_t     dec
);
  logic is_pair;
  logic is_abs;

  always_comb begin
    is_pair = (opcode & 16'hFFF8) == 16'hF620;
    is_abs  = (opcode & 16'hFFE0) == 16'hF600;
    dec     = '0;
    if (is_pair) begin
      dec.legal   = ext_hi[3];
      dec.src_sel = opcode[2:0];
      dec.dst_sel = ext_hi[2:0];
      dec.inc_src = 1'b1;
      dec.inc_dst = 1'b1;
    end else if (is_abs) begin
      dec.legal   = 1'b1;
      dec.src_sel = opcode[2:0];
      dec.dst_sel = opcode[2:0];
      dec.src_abs = opcode[3];
      dec.dst_abs = ~opcode[3];
      dec.inc_src = ~opcode[4] & ~opcode[3];
      dec.inc_dst = ~opcode[4] &  opcode[3];
    end
  end
endmodule

// File: rtl/lm_seq.sv
module lm_seq
  import lm_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int LINE_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_line,
  input  logic [AW-1:0] dst_line,
  input  logic          user_in,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          fin,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_user
);
  localparam int BEAT_BYTES = DW / 8;
  localparam int NBEATS     = LINE_BYTES / BEAT_BYTES;
  localparam int BCW        = (NBEATS > 1) ? $clog2(NBEATS) : 1;
  localparam int BOFF       = $clog2(BEAT_BYTES);
  localparam logic [BCW-1:0] LAST_BEAT = BCW'(NBEATS - 1);

  lm_state_t      state_q;
  logic [BCW-1:0] beat_q;
  logic [AW-1:0]  src_q;
  logic [AW-1:0]  dst_q;
  logic           user_q;
  logic [DW-1:0]  line_q [NBEATS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      user_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_READ;
          beat_q  <= '0;
          src_q   <= src_line;
          dst_q   <= dst_line;
          user_q  <= user_in;
        end
        ST_READ: if (mem_ack) begin
          if (beat_q == LAST_BEAT) begin
            state_q <= ST_WRITE;
            beat_q  <= '0;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_WRITE: if (mem_ack) begin
          if (beat_q == LAST_BEAT) begin
            state_q <= ST_FIN;
            beat_q  <= '0;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // line buffer: filled by read beats, drained by write beats
  always_ff @(posedge clk) begin
    if (state_q == ST_READ && mem_ack) line_q[beat_q] <= mem_rdata;
  end

  always_comb begin
    busy      = state_q != ST_IDLE;
    fin       = state_q == ST_FIN;
    mem_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
    mem_we    = state_q == ST_WRITE;
    mem_addr  = ((state_q == ST_WRITE) ? dst_q : src_q) + (AW'(beat_q) << BOFF);
    mem_wdata = line_q[beat_q];
    mem_user  = user_q;
  end
endmodule

// File: rtl/lm_wb.sv
module lm_wb
  import lm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 8
) (
  input  logic                fin,
  input  logic [LM_SEL_W-1:0] src_sel,
  input  logic [LM_SEL_W-1:0] dst_sel,
  input  logic                inc_src,
  input  logic                inc_dst,
  input  logic [AW-1:0]       src_next,
  input  logic [AW-1:0]       dst_next,
  output logic [NREG-1:0]     wr_en,
  output logic [NREG*AW-1:0]  wr_data
);
  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic hit_src;
    logic hit_dst;
    assign hit_src = inc_src && (src_sel == LM_SEL_W'(i));
    assign hit_dst = inc_dst && (dst_sel == LM_SEL_W'(i));
    assign wr_en[i] = fin && (hit_src || hit_dst);
    assign wr_data[i*AW +: AW] = hit_dst ? dst_next : src_next;
  end
endmodule

// File: rtl/line_mover.sv
module line_mover
  import lm_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int LINE_BYTES = 16,
  parameter int NREG       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [15:0]        cmd_opcode,
  input  logic [AW-1:0]      cmd_ext,
  input  logic               user_mode,
  input  logic [NREG*AW-1:0] areg_q,
  output logic [NREG-1:0]    areg_wr_en,
  output logic [NREG*AW-1:0] areg_wr_data,
  output logic               mem_valid,
  input  logic               mem_ack,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  output logic               mem_user,
  output logic               busy,
  output logic               done,
  output logic               illegal
);
  localparam logic [AW-1:0] LINE_MASK = ~AW'(LINE_BYTES - 1);
  localparam logic [AW-1:0] STEP      = AW'(LINE_BYTES);

  lm_dec_t dec;
  logic    accept;
  logic    start;
  logic [AW-1:0] src_reg, dst_reg, src_line, dst_line;

  logic                illegal_q;
  logic [LM_SEL_W-1:0] src_sel_q, dst_sel_q;
  logic                inc_src_q, inc_dst_q;
  logic [AW-1:0]       src_next_q, dst_next_q;

  lm_decode u_dec (
    .opcode (cmd_opcode),
    .ext_hi (cmd_ext[15:12]),
    .dec    (dec)
  );

  assign cmd_ready = ~busy;
  assign accept    = cmd_valid && cmd_ready;
  assign start     = accept && dec.legal;
  assign src_reg   = areg_q[dec.src_sel*AW +: AW];
  assign dst_reg   = areg_q[dec.dst_sel*AW +: AW];
  assign src_line  = (dec.src_abs ? cmd_ext : src_reg) & LINE_MASK;
  assign dst_line  = (dec.dst_abs ? cmd_ext : dst_reg) & LINE_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal_q  <= 1'b0;
      src_sel_q  <= '0;
      dst_sel_q  <= '0;
      inc_src_q  <= 1'b0;
      inc_dst_q  <= 1'b0;
      src_next_q <= '0;
      dst_next_q <= '0;
    end else begin
      illegal_q <= accept && !dec.legal;
      if (start) begin
        src_sel_q  <= dec.src_sel;
        dst_sel_q  <= dec.dst_sel;
        inc_src_q  <= dec.inc_src;
        inc_dst_q  <= dec.inc_dst;
        src_next_q <= src_reg + STEP;
        dst_next_q <= dst_reg + STEP;
      end
    end
  end

  assign illegal = illegal_q;

  lm_seq #(.AW(AW), .DW(DW), .LINE_BYTES(LINE_BYTES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_line  (src_line),
    .dst_line  (dst_line),
    .user_in   (user_mode),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .fin       (done),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_user  (mem_user)
  );

  lm_wb #(.AW(AW), .NREG(NREG)) u_wb (
    .fin      (done),
    .src_sel  (src_sel_q),
    .dst_sel  (dst_sel_q),
    .inc_src  (inc_src_q),
    .inc_dst  (inc_dst_q),
    .src_next (src_next_q),
    .dst_next (dst_next_q),
    .wr_en    (areg_wr_en),
    .wr_data  (areg_wr_data)
  );
endmodule

// File: rtl/lm_chk.sv
module lm_chk #(
  parameter int AW   = 32,
  parameter int DW   = 64,
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [NREG-1:0] areg_wr_en,
  input logic            mem_valid,
  input logic            mem_ack,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic            mem_user,
  input logic            busy,
  input logic            done,
  input logic            illegal
);
  localparam int BOFF = $clog2(DW / 8);

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata) && $stable(mem_user));

  // R2
  beat_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[BOFF-1:0] == '0);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|areg_wr_en) |-> done);

  // R5
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_valid && !busy && (areg_wr_en == '0));

  // R11
  accept_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy || illegal);

  // R3
  write_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_valid) && $past(mem_we) && $past(mem_ack));
endmodule

bind line_mover lm_chk #(.AW(AW), .DW(DW), .NREG(NREG)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .areg_wr_en (areg_wr_en),
  .mem_valid  (mem_valid),
  .mem_ack    (mem_ack),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_user   (mem_user),
  .busy       (busy),
  .done       (done),
  .illegal    (illegal)
);

// File: tb/line_mover_tb_top.sv
`timescale 1ns/1ps
module line_mover_tb_top;
  typedef struct packed {
    logic [15:0] op;
    logic [31:0] ext;
    logic        user;
    logic [1:0]  lat;
    logic        exp_ill;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'hF620, 32'h0000_9000, 1'b0, 2'd0, 1'b0},  // pair A0->A1
    '{16'hF623, 32'h0000_D000, 1'b1, 2'd2, 1'b0},  // pair A3->A5
    '{16'hF624, 32'h0000_C000, 1'b0, 2'd1, 1'b0},  // pair same reg A4
    '{16'hF622, 32'h0000_2000, 1'b0, 2'd0, 1'b1},  // ext bit15 clear
    '{16'hF602, 32'h0000_0237, 1'b0, 2'd0, 1'b0},  // A2 -> abs, inc
    '{16'hF60E, 32'h0000_03F9, 1'b1, 2'd3, 1'b0},  // abs -> A6, inc
    '{16'hF615, 32'h0000_0100, 1'b0, 2'd1, 1'b0},  // A5 -> abs, no inc
    '{16'hF61F, 32'h0000_02C4, 1'b1, 2'd2, 1'b0},  // abs -> A7, no inc
    '{16'hF640, 32'h0000_0000, 1'b0, 2'd0, 1'b1},  // unknown opcode
    '{16'hF628, 32'h0000_8000, 1'b0, 2'd0, 1'b1}   // near miss opcode
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [15:0]  cmd_opcode = '0;
  logic [31:0]  cmd_ext = '0;
  logic         user_mode = 1'b0;
  logic [255:0] areg_q;
  logic [7:0]   areg_wr_en;
  logic [255:0] areg_wr_data;
  logic         mem_valid, mem_we, mem_user;
  logic         mem_ack = 1'b0;
  logic [31:0]  mem_addr;
  logic [63:0]  mem_wdata;
  logic [63:0]  mem_rdata = '0;
  logic         busy, done, illegal;

  int checks = 0;
  int errors = 0;
  int wb_bad = 0;
  int lat_cfg = 0;

  always #10 clk = ~clk;

  line_mover dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opcode(cmd_opcode), .cmd_ext(cmd_ext), .user_mode(user_mode),
    .areg_q(areg_q), .areg_wr_en(areg_wr_en), .areg_wr_data(areg_wr_data),
    .mem_valid(mem_valid), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_user(mem_user), .busy(busy), .done(done), .illegal(illegal)
  );

  // register bank model
  logic [31:0] regs [8];
  function automatic logic [31:0] reg_init(int i);
    return 32'h0000_0080 * i + i + 5;
  endfunction
  always @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (!rst_n) regs[i] <= reg_init(i);
      else if (areg_wr_en[i]) regs[i] <= areg_wr_data[i*32 +: 32];
    end
  end
  always_comb for (int i = 0; i < 8; i++) areg_q[i*32 +: 32] = regs[i];

  // memory responder with a beat log
  logic [63:0] mem [128];
  logic [31:0] log_addr [64];
  logic        log_we   [64];
  logic [63:0] log_data [64];
  logic        log_user [64];
  int beat_n = 0;
  int wait_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
      for (int k = 0; k < 128; k++) mem[k] = {32'hFACE_0000 + k, 32'h1234_0000 ^ k};
    end else if (mem_ack) begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end else if (mem_valid) begin
      if (wait_cnt >= lat_cfg) begin
        mem_ack = 1'b1;
        log_addr[beat_n % 64] = mem_addr;
        log_we[beat_n % 64]   = mem_we;
        log_user[beat_n % 64] = mem_user;
        if (mem_we) begin
          mem[mem_addr[9:3]] = mem_wdata;
          log_data[beat_n % 64] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[9:3]];
          log_data[beat_n % 64] = mem[mem_addr[9:3]];
        end
        beat_n++;
      end else begin
        wait_cnt++;
      end
    end
  end

  // write strobes outside the done cycle (R10)
  always @(negedge clk) if (rst_n && (|areg_wr_en) && !done) wb_bad++;

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run hung got %0d exp %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic run_cmd(input vec_t v, input string tag);
    logic [31:0] er [8];
    logic [31:0] es, ed;
    logic [2:0]  s, d;
    int base, n;
    bit pair, absf, regs_ok;
    for (int i = 0; i < 8; i++) er[i] = regs[i];
    es = 0; ed = 0;
    pair = (v.op & 16'hFFF8) == 16'hF620;
    absf = (v.op & 16'hFFE0) == 16'hF600;
    if (pair) begin
      s = v.op[2:0]; d = v.ext[14:12];
      es = regs[s]; ed = regs[d];
      er[s] = regs[s] + 32'd16;
      er[d] = regs[d] + 32'd16;
    end else if (absf) begin
      s = v.op[2:0];
      if (v.op[3]) begin es = v.ext; ed = regs[s]; end
      else begin es = regs[s]; ed = v.ext; end
      if (!v.op[4]) er[s] = regs[s] + 32'd16;
    end
    es = es & ~32'hF;
    ed = ed & ~32'hF;
    base = beat_n;
    lat_cfg = v.lat;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = v.op; cmd_ext = v.ext; user_mode = v.user;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (v.exp_ill) begin
      chk(illegal == 1'b1 && mem_valid == 1'b0 && cmd_ready == 1'b1,
          "R5", {tag, " illegal pulse"}, {61'd0, illegal, mem_valid, cmd_ready}, 64'h5);
      @(negedge clk);
      chk(illegal == 1'b0, "R5", {tag, " illegal one cycle"}, 64'(illegal), 64'd0);
      repeat (3) @(negedge clk);
      chk(beat_n == base, "R1", {tag, " no beats"}, 64'(beat_n - base), 64'd0);
    end else begin
      chk(busy == 1'b1 && cmd_ready == 1'b0, "R11", {tag, " busy after accept"},
          {62'd0, busy, cmd_ready}, 64'h2);
      n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      chk(done == 1'b1, "R10", {tag, " done seen"}, 64'(done), 64'd1);
      chk(beat_n - base == 4, "R3", {tag, " beat count"}, 64'(beat_n - base), 64'd4);
      chk(log_addr[base % 64] == es && log_addr[(base + 1) % 64] == es + 8,
          "R2", {tag, " read addrs"}, {log_addr[base % 64], log_addr[(base + 1) % 64]},
          {es, es + 32'd8});
      chk(log_addr[(base + 2) % 64] == ed && log_addr[(base + 3) % 64] == ed + 8,
          "R7", {tag, " write addrs"}, {log_addr[(base + 2) % 64], log_addr[(base + 3) % 64]},
          {ed, ed + 32'd8});
      chk({log_we[base % 64], log_we[(base + 1) % 64], log_we[(base + 2) % 64],
           log_we[(base + 3) % 64]} == 4'b0011, "R3", {tag, " beat order"},
          64'({log_we[base % 64], log_we[(base + 1) % 64], log_we[(base + 2) % 64],
               log_we[(base + 3) % 64]}), 64'h3);
      chk(log_data[(base + 2) % 64] == log_data[base % 64] &&
          log_data[(base + 3) % 64] == log_data[(base + 1) % 64], "R3", {tag, " data"},
          log_data[(base + 2) % 64], log_data[base % 64]);
      chk({log_user[base % 64], log_user[(base + 3) % 64]} == {v.user, v.user},
          "R9", {tag, " user tag"}, 64'({log_user[base % 64], log_user[(base + 3) % 64]}),
          64'({v.user, v.user}));
      @(negedge clk);
      regs_ok = 1'b1;
      for (int i = 0; i < 8; i++) if (regs[i] != er[i]) begin
        regs_ok = 1'b0;
        $display("FAIL R6/R8 %s reg %0d: got %h exp %h", tag, i, regs[i], er[i]);
      end
      checks++;
      if (!regs_ok) errors++;
      chk(cmd_ready == 1'b1 && done == 1'b0, "R11", {tag, " ready after done"},
          {62'd0, cmd_ready, done}, 64'h2);
    end
  endtask

  initial begin
    int base;
    bit held;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(mem_valid == 0 && busy == 0 && done == 0 && illegal == 0 && cmd_ready == 1 &&
        areg_wr_en == 0, "R12", "reset outputs",
        {56'd0, areg_wr_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R6 R7 R8: table walk
    for (int k = 0; k < NV; k++) run_cmd(VECS[k], $sformatf("vec%0d", k));

    // R11: command offered while busy is not taken
    base = beat_n;
    lat_cfg = 3;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = 16'hF621; cmd_ext = 32'h0000_A000; user_mode = 1'b0;
    @(negedge clk);
    cmd_opcode = 16'hF600; cmd_ext = 32'h0000_0000;
    held = 1'b1;
    repeat (4) begin
      if (cmd_ready) held = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(held, "R11", "ready low while busy", 64'(held), 64'd1);
    while (!done) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(beat_n - base == 4 && busy == 0, "R11", "blocked command ignored",
        64'(beat_n - base), 64'd4);

    // R12: reset in the middle of a move
    base = beat_n;
    lat_cfg = 3;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_opcode = 16'hF627; cmd_ext = 32'h0000_E000;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(mem_valid == 0 && busy == 0 && cmd_ready == 1 && areg_wr_en == 0, "R12",
        "mid-move reset", {60'd0, mem_valid, busy, cmd_ready, |areg_wr_en}, 64'h2);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(regs[7] == reg_init(7) && regs[6] == reg_init(6), "R12", "abandoned move no writes",
        64'(regs[6]), 64'(reg_init(6)));

    // R10: strobes confined to done
    chk(wb_bad == 0, "R10", "write strobes outside done", 64'(wb_bad), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule